// File: doc/BRIEF.md
# Flagless Skip-Condition Execute Unit

This block is the single-cycle execute stage of a small 32-bit core that has no status-flag register. It takes one 16-bit instruction word per cycle, points two read ports of an external bank of sixteen 32-bit registers at the operands named in the word, computes the result, and returns a write-back request for the destination register. Compare-type instructions never store a flag. The condition is evaluated inside the instruction, and the only visible effect is a one-cycle skip strobe that tells the sequencer to discard the next program word.

The supported work is bitwise AND and XOR, a wrapping add, subtract-with-skip-on-borrow, a 16x16 unsigned multiply, increment by a signed 4-bit immediate, single-bit logical and arithmetic right shifts, inversion, and two swap forms. Opcodes and sub-operations outside this set produce neither a write nor a skip. The read addresses are combinational from the instruction. The write-back request and the skip strobe are registered and appear on the clock edge that ends the instruction's cycle.

Top module: `skip_exec_unit`

## Requirements
- R1: Read port Y always addresses bits 11:8 of the word and read port X always addresses bits 3:0, combinationally; the write-back address is bits 7:4 and the opcode is bits 15:12.
- R2: Opcode 0000 writes Y AND X, opcode 0001 writes the 32-bit wrapping sum Y + X, and opcode 0010 writes Y XOR X; none of them skips.
- R3: Opcode 0011 with bits 7:4 = 0100 skips when (Y AND X) is zero, and with bits 7:4 = 0000 skips when it is non-zero; neither writes.
- R4: Opcode 0011 with bits 7:5 = 110 skips when bit n of Y is 0, and with bits 7:5 = 100 skips when bit n of Y is 1, where n = bits 4:0 (0 to 31); neither writes.
- R5: Opcode 0100 always writes Y - X modulo 2^32 and, in the same cycle, skips when Y < X unsigned.
- R6: Opcode 0101 writes the unsigned 32-bit product of the low 16 bits of Y and X.
- R7: Opcode 1010 writes Y plus the sign-extended 4-bit immediate in bits 3:0; an immediate of 0 copies Y.
- R8: Opcode 1101 with bits 11:8 = 0000 writes X shifted right by one with the MSB cleared, 0001 writes X shifted right by one with the MSB kept, and 0010 writes the bitwise inverse of X.
- R9: Opcode 1100 with bits 11:8 = 0000 swaps the two bytes of the low half of X and keeps the upper half; 0001 exchanges the two 16-bit halves of X.
- R10: The write-back request and skip strobe appear one clock after a valid instruction, last exactly one cycle, are low in any cycle after the valid input was low, and are low out of reset.
- R11: Opcodes 0110 to 1001, 1011, 1110 and 1111, sub-ops 0010 to 1111 under 1100, sub-ops 0011 to 1111 under 1101, and any other bits 7:4 pattern under 0011 produce neither a write nor a skip.
- R12: The all-zero word writes register 0 with its own value and does not skip, so it behaves as a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | The instruction word is to be executed in this cycle |
| instrWord | input | 16 | Instruction word |
| rdAddrY | output | 4 | Register address of the Y operand |
| rdAddrX | output | 4 | Register address of the X operand |
| rdDataY | input | 32 | Register contents at rdAddrY |
| rdDataX | input | 32 | Register contents at rdAddrX |
| wbEn | output | 1 | Write-back request, one cycle |
| wbAddr | output | 4 | Destination register |
| wbData | output | 32 | Value to write |
| skipNext | output | 1 | Discard the next program word, one cycle |

## Verification
The only case where the unit asks for a register write and a skip in the same cycle is subtract-with-skip when Y is below X. Vectors drive that opcode with Y below, equal to and above X. The bench expects both strobes high together only in the first case, and expects the written value to be the wrapped difference. It also places a skipping instruction directly before an idle cycle, to judge that the strobe does not linger into the next cycle.

// File: rtl/skx_pkg.sv
package skx_pkg;
  parameter int DATA_W  = 32;
  parameter int FIELD_W = 4;
  parameter int INSTR_W = 4 * FIELD_W;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = HALF_W / 2;

  typedef enum logic [3:0] {
    RES_AND, RES_ADD, RES_XOR, RES_SUB, RES_MUL, RES_INC,
    RES_LSR, RES_ASR, RES_NOT, RES_SWB, RES_SWH
  } resSel_e;

  typedef enum logic [2:0] {
    SKIP_NONE, SKIP_ANDZ, SKIP_ANDNZ, SKIP_BITZ, SKIP_BITNZ, SKIP_BORROW
  } skipMode_e;

  typedef struct packed {
    logic      wr;
    resSel_e   resSel;
    skipMode_e skipMode;
  } ctrl_t;
endpackage

// File: rtl/skx_ctrl.sv
module skx_ctrl
  import skx_pkg::*;
(
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  localparam int OP_LO  = 3 * FIELD_W;
  localparam int Y_LO   = 2 * FIELD_W;
  localparam int Z_LO   = FIELD_W;

  logic [FIELD_W-1:0] opField;
  logic [FIELD_W-1:0] yField;
  logic [FIELD_W-1:0] zField;

  assign opField = instr[OP_LO +: FIELD_W];
  assign yField  = instr[Y_LO +: FIELD_W];
  assign zField  = instr[Z_LO +: FIELD_W];

  always_comb begin
    ctrl          = '0;
    ctrl.resSel   = RES_AND;
    ctrl.skipMode = SKIP_NONE;
    if (valid) begin
      unique case (opField)
        4'b0000: begin ctrl.wr = 1'b1; ctrl.resSel = RES_AND; end
        4'b0001: begin ctrl.wr = 1'b1; ctrl.resSel = RES_ADD; end
        4'b0010: begin ctrl.wr = 1'b1; ctrl.resSel = RES_XOR; end
        4'b0011: begin
          if (zField == 4'b0100)              ctrl.skipMode = SKIP_ANDZ;
          else if (zField == 4'b0000)         ctrl.skipMode = SKIP_ANDNZ;
          else if (zField[3:1] == 3'b110)     ctrl.skipMode = SKIP_BITZ;
          else if (zField[3:1] == 3'b100)     ctrl.skipMode = SKIP_BITNZ;
          else                                ctrl.skipMode = SKIP_NONE;
        end
        4'b0100: begin
          ctrl.wr = 1'b1; ctrl.resSel = RES_SUB; ctrl.skipMode = SKIP_BORROW;
        end
        4'b0101: begin ctrl.wr = 1'b1; ctrl.resSel = RES_MUL; end
        4'b1010: begin ctrl.wr = 1'b1; ctrl.resSel = RES_INC; end
        4'b1100: begin
          if (yField == 4'b0000)      begin ctrl.wr = 1'b1; ctrl.resSel = RES_SWB; end
          else if (yField == 4'b0001) begin ctrl.wr = 1'b1; ctrl.resSel = RES_SWH; end
        end
        4'b1101: begin
          if (yField == 4'b0000)      begin ctrl.wr = 1'b1; ctrl.resSel = RES_LSR; end
          else if (yField == 4'b0001) begin ctrl.wr = 1'b1; ctrl.resSel = RES_ASR; end
          else if (yField == 4'b0010) begin ctrl.wr = 1'b1; ctrl.resSel = RES_NOT; end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/skx_datapath.sv
module skx_datapath
  import skx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [DATA_W-1:0]  yData,
  input  logic [DATA_W-1:0]  xData,
  input  logic [FIELD_W-1:0] zAddr,
  input  logic [IDX_W-1:0]   immLow,
  output logic               wbEn,
  output logic [FIELD_W-1:0] wbAddr,
  output logic [DATA_W-1:0]  wbData,
  output logic               skipNext
);
  logic [DATA_W-1:0] andVal;
  logic [DATA_W-1:0] diffVal;
  logic [DATA_W-1:0] incVal;
  logic [DATA_W-1:0] result;
  logic              borrow;
  logic              selBit;
  logic              skipCond;

  assign andVal = yData & xData;
  assign {borrow, diffVal} = {1'b0, yData} - {1'b0, xData};
  assign incVal = yData + {{(DATA_W-FIELD_W){immLow[FIELD_W-1]}}, immLow[FIELD_W-1:0]};
  assign selBit = yData[immLow];

  always_comb begin
    unique case (ctrl.resSel)
      RES_AND: result = andVal;
      RES_ADD: result = yData + xData;
      RES_XOR: result = yData ^ xData;
      RES_SUB: result = diffVal;
      RES_MUL: result = DATA_W'(yData[HALF_W-1:0] * xData[HALF_W-1:0]);
      RES_INC: result = incVal;
      RES_LSR: result = {1'b0, xData[DATA_W-1:1]};
      RES_ASR: result = {xData[DATA_W-1], xData[DATA_W-1:1]};
      RES_NOT: result = ~xData;
      RES_SWB: result = {xData[DATA_W-1:HALF_W], xData[BYTE_W-1:0], xData[HALF_W-1:BYTE_W]};
      RES_SWH: result = {xData[HALF_W-1:0], xData[DATA_W-1:HALF_W]};
      default: result = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.skipMode)
      SKIP_ANDZ:   skipCond = (andVal == '0);
      SKIP_ANDNZ:  skipCond = (andVal != '0);
      SKIP_BITZ:   skipCond = !selBit;
      SKIP_BITNZ:  skipCond = selBit;
      SKIP_BORROW: skipCond = borrow;
      default:     skipCond = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn     <= 1'b0;
      wbAddr   <= '0;
      wbData   <= '0;
      skipNext <= 1'b0;
    end else begin
      wbEn     <= ctrl.wr;
      wbAddr   <= zAddr;
      wbData   <= result;
      skipNext <= skipCond;
    end
  end

  // R10: a skip strobe only follows a cycle whose control asked for a condition
  assert_skip_has_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    skipNext |-> $past(ctrl.skipMode != SKIP_NONE));

  // R10: a write request only follows a cycle whose control asked for one
  assert_write_has_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(ctrl.wr));
endmodule

// File: rtl/skip_exec_unit.sv
module skip_exec_unit
  import skx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic [FIELD_W-1:0] rdAddrY,
  output logic [FIELD_W-1:0] rdAddrX,
  input  logic [DATA_W-1:0]  rdDataY,
  input  logic [DATA_W-1:0]  rdDataX,
  output logic               wbEn,
  output logic [FIELD_W-1:0] wbAddr,
  output logic [DATA_W-1:0]  wbData,
  output logic               skipNext
);
  ctrl_t ctrl;

  assign rdAddrY = instrWord[2*FIELD_W +: FIELD_W];
  assign rdAddrX = instrWord[0 +: FIELD_W];

  skx_ctrl ctrl_i (
    .valid (instrValid),
    .instr (instrWord),
    .ctrl  (ctrl)
  );

  skx_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .yData    (rdDataY),
    .xData    (rdDataX),
    .zAddr    (instrWord[FIELD_W +: FIELD_W]),
    .immLow   (instrWord[IDX_W-1:0]),
    .wbEn     (wbEn),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .skipNext (skipNext)
  );

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> (!wbEn && !skipNext));

  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:12] == 4'b0011) |=> !wbEn);

  assert_borrow_both_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:12] == 4'b0100 && rdDataY < rdDataX) |=> (wbEn && skipNext));

  assert_lsr_msb_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:8] == 8'hD0) |=> (wbEn && !wbData[DATA_W-1]));

  assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && (instrWord[15:12] inside {4'b0110, 4'b0111, 4'b1000, 4'b1001,
                                             4'b1011, 4'b1110, 4'b1111}))
    |=> (!wbEn && !skipNext));
endmodule

// File: tb/skip_exec_unit_tb.sv
module skip_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [3:0]  rdAddrY, rdAddrX, wbAddr;
  logic [31:0] rdDataY, rdDataX, wbData;
  logic        wbEn, skipNext;
  logic [31:0] regs [16];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign rdDataY = regs[rdAddrY];
  assign rdDataX = regs[rdAddrX];

  skip_exec_unit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .rdAddrY(rdAddrY), .rdAddrX(rdAddrX), .rdDataY(rdDataY), .rdDataX(rdDataX),
    .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData), .skipNext(skipNext)
  );

  // {word, expected write, expected data, expected skip, requirement number}
  localparam int NV = 34;
  localparam logic [53:0] VECS [NV] = '{
    {16'h0291, 1'b1, 32'h0000_0034, 1'b0, 4'd2},   // R2 AND
    {16'h16A4, 1'b1, 32'h0000_0004, 1'b0, 4'd2},   // R2 ADD wraps
    {16'h22B1, 1'b1, 32'hFFFF_12CB, 1'b0, 4'd2},   // R2 XOR
    {16'h3142, 1'b0, 32'h0,         1'b0, 4'd3},   // R3 zero-test, value 0x34
    {16'h3102, 1'b0, 32'h0,         1'b1, 4'd3},   // R3 nonzero-test, value 0x34
    {16'h3140, 1'b0, 32'h0,         1'b1, 4'd3},   // R3 zero-test, value 0
    {16'h3100, 1'b0, 32'h0,         1'b0, 4'd3},   // R3 nonzero-test, value 0
    {16'h33DF, 1'b0, 32'h0,         1'b0, 4'd4},   // R4 bit 31 of R3 is 1, skip-if-0
    {16'h339F, 1'b0, 32'h0,         1'b1, 4'd4},   // R4 bit 31 skip-if-1
    {16'h33C1, 1'b0, 32'h0,         1'b1, 4'd4},   // R4 bit 1 is 0, skip-if-0
    {16'h3380, 1'b0, 32'h0,         1'b1, 4'd4},   // R4 bit 0 skip-if-1
    {16'h3381, 1'b0, 32'h0,         1'b0, 4'd4},   // R4 bit 1 skip-if-1
    {16'h45C4, 1'b1, 32'h0000_0002, 1'b0, 4'd5},   // R5 Y above X
    {16'h44C5, 1'b1, 32'hFFFF_FFFE, 1'b1, 4'd5},   // R5 Y below X: write and skip
    {16'h45C5, 1'b1, 32'h0000_0000, 1'b0, 4'd5},   // R5 Y equal X
    {16'h51D2, 1'b1, 32'h0012_21CC, 1'b0, 4'd6},   // R6 low halves only
    {16'h56E6, 1'b1, 32'hFFFE_0001, 1'b0, 4'd6},   // R6 largest product
    {16'hA4EF, 1'b1, 32'h0000_0004, 1'b0, 4'd7},   // R7 minus one
    {16'hA0E7, 1'b1, 32'h0000_0007, 1'b0, 4'd7},   // R7 plus seven
    {16'hA0E8, 1'b1, 32'hFFFF_FFF8, 1'b0, 4'd7},   // R7 minus eight
    {16'hA1E0, 1'b1, 32'hF0F0_1234, 1'b0, 4'd7},   // R7 move
    {16'hD0F3, 1'b1, 32'h4000_0000, 1'b0, 4'd8},   // R8 logical shift
    {16'hD1F3, 1'b1, 32'hC000_0000, 1'b0, 4'd8},   // R8 arithmetic shift
    {16'hD0F6, 1'b1, 32'h7FFF_FFFF, 1'b0, 4'd8},   // R8 logical shift of all ones
    {16'hD1F6, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'd8},   // R8 arithmetic shift of all ones
    {16'hD2F1, 1'b1, 32'h0F0F_EDCB, 1'b0, 4'd8},   // R8 inversion
    {16'hC0F1, 1'b1, 32'hF0F0_3412, 1'b0, 4'd9},   // R9 byte swap keeps upper half
    {16'hC1F1, 1'b1, 32'h1234_F0F0, 1'b0, 4'd9},   // R9 half swap
    {16'h0000, 1'b1, 32'h0000_0000, 1'b0, 4'd12},  // R12 all-zero word
    {16'h6123, 1'b0, 32'h0,         1'b0, 4'd11},  // R11 unused opcode
    {16'hD3F1, 1'b0, 32'h0,         1'b0, 4'd11},  // R11 unused shift sub-op
    {16'hC2F1, 1'b0, 32'h0,         1'b0, 4'd11},  // R11 unused swap sub-op
    {16'h3110, 1'b0, 32'h0,         1'b0, 4'd11},  // R11 unused test pattern
    {16'hF102, 1'b0, 32'h0,         1'b0, 4'd11}   // R11 unused opcode
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runWord(input logic [15:0] w, input logic v);
    @(negedge clk);
    instrWord  = w;
    instrValid = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0000_0100 * i;
    regs[0] = 32'h0000_0000;
    regs[1] = 32'hF0F0_1234;
    regs[2] = 32'h0F0F_00FF;
    regs[3] = 32'h8000_0001;
    regs[4] = 32'h0000_0005;
    regs[5] = 32'h0000_0007;
    regs[6] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset wbEn", {31'b0, wbEn}, 32'h0);
    check("R10", "reset skip", {31'b0, skipNext}, 32'h0);
    rstN = 1'b1;

    // R1 combinational read addresses
    @(negedge clk);
    instrWord = 16'h4A5B;
    #1;
    check("R1", "rdAddrY", {28'b0, rdAddrY}, 32'hA);
    check("R1", "rdAddrX", {28'b0, rdAddrX}, 32'hB);

    for (int i = 0; i < NV; i++) begin
      string req;
      logic [15:0] w;
      req = $sformatf("R%0d", VECS[i][3:0]);
      w = VECS[i][53:38];
      runWord(w, 1'b1);
      check(req, $sformatf("wbEn word %h", w), {31'b0, wbEn}, {31'b0, VECS[i][37]});
      check(req, $sformatf("skip word %h", w), {31'b0, skipNext}, {31'b0, VECS[i][4]});
      if (VECS[i][37]) begin
        check(req, $sformatf("data word %h", w), wbData, VECS[i][36:5]);
        check("R1", $sformatf("wbAddr word %h", w), {28'b0, wbAddr}, {28'b0, w[7:4]});
      end
    end

    // R10: skipping word with valid low has no effect
    runWord(16'h3102, 1'b0);
    check("R10", "idle skip", {31'b0, skipNext}, 32'h0);
    check("R10", "idle wbEn", {31'b0, wbEn}, 32'h0);

    // R10: skip lasts exactly one cycle when followed by idle
    runWord(16'h44C5, 1'b1);
    check("R10", "pulse high", {31'b0, skipNext}, 32'h1);
    instrValid = 1'b0;
    @(negedge clk);
    check("R10", "pulse gone skip", {31'b0, skipNext}, 32'h0);
    check("R10", "pulse gone wbEn", {31'b0, wbEn}, 32'h0);

    // R10: reset clears a pending strobe
    runWord(16'h3102, 1'b1);
    instrValid = 1'b0;
    rstN = 1'b0;
    #1;
    check("R10", "async reset skip", {31'b0, skipNext}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule